// File: doc/BRIEF.md
# Timer Channel Count and Status Access Unit

This unit is the byte-wide register front end of one channel of a programmable interval timer. It sits between an 8-bit bus decoder and a 16-bit down-counting element. Decoded strobes arrive as single-cycle pulses: a configuration write, a count byte write, a count byte read, a count-freeze request and a status-freeze request. The unit gathers count bytes into a 16-bit initial value and hands it to the counting logic. It serves reads of the live count, of a frozen copy of the count, or of a status byte. It also keeps the null-count flag, which tells software that a written count has not yet reached the counting element.

The 6-bit configuration word holds a byte format in bits 5:4, a mode in bits 3:1 and a decimal flag in bit 0. Only the byte format matters to this unit. Mode and decimal flag are stored so that the status byte can report them. Reads and writes keep separate byte pointers, so the two kinds of access can interleave on one channel.

Top module: `cnt_access_unit`

## Requirements
- R1: After synchronous reset `rd_data`, `init_cnt` and `cnt_written` are 0, the null flag is 0 and the stored configuration is 0x30 (two-byte format, mode 0, binary).
- R2: An accepted configuration write clears both bytes of the count register. With format 01 (low byte only) a count write yields `init_cnt` = {0x00, byte}. With format 10 (high byte only) it yields {byte, 0x00}.
- R3: With format 11 the first count byte is the low byte and raises no pulse. The second byte is the high byte, and both bytes are passed on together. `cnt_written` is high for exactly the one cycle after the clock edge that takes a completing byte, and `init_cnt` changes on that same edge.
- R4: Reads follow the format: 01 returns the low byte, 10 returns the high byte, 11 returns the low byte and then the high byte. `rd_data` is updated on the edge that takes `cnt_rd` and holds until the next read.
- R5: A count-freeze request captures `live_cnt`. Reads return the captured value until the whole count has been read in the current format. After that, reads return `live_cnt` again.
- R6: A count-freeze request is ignored while a frozen count is unread. A status-freeze request is ignored while a frozen status is unread.
- R7: When status and count are both frozen, the next read returns the status, whatever order they were frozen in. The following one or two reads return the count.
- R8: The status byte is {`out_level`, null flag, configuration[5:0]}, with the values captured on the edge that takes the status-freeze request.
- R9: The null flag is set by an accepted configuration write and by a completing count write (in format 11, by the second byte). It is cleared by `load_done`. A set wins when both happen in the same cycle.
- R10: Read and write byte pointers are independent. For example: read low, write low, read high, write high returns both halves of the count and loads the written pair.
- R11: An accepted configuration write returns both byte pointers to the low byte and drops any pending count or status freeze.
- R12: A configuration write with format 00 is ignored: configuration, null flag, pointers and count register do not change.
- R13: With the decimal flag set, bytes pass through unchanged, with no decimal conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe for this channel |
| cfg_data | input | 6 | Configuration word: format[5:4], mode[3:1], decimal[0] |
| cnt_wr | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Count byte being written |
| cnt_rd | input | 1 | Count/status byte read strobe |
| frz_cnt | input | 1 | Count-freeze request |
| frz_sts | input | 1 | Status-freeze request |
| live_cnt | input | 16 | Current value of the counting element |
| out_level | input | 1 | Current channel output pin level |
| load_done | input | 1 | Pulse: counting logic has taken the initial count |
| init_cnt | output | 16 | Last complete initial count |
| cnt_written | output | 1 | One-cycle pulse after a complete count write |
| rd_data | output | 8 | Byte returned by the last read |

## Verification
The bench builds the unit with its default byte width of 8. That gives a 16-bit count and a 6-bit configuration field, so every byte position, status bit and format code listed above can be checked directly at the ports. With this width, the full format cycle becomes reachable: single-byte, high-only and two-byte writes, followed by reads that interleave with writes, stack a status freeze on top of a count freeze, or are cut short by a new configuration. Byte values that are not decimal digits are used in decimal mode, so any conversion would show up.

// File: rtl/cau_pkg.sv
package cau_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_BOTH = 2'b11
  } fmt_e;

  localparam int CFG_FMT_MSB = 5;
  localparam int CFG_FMT_LSB = 4;
endpackage

// File: rtl/cau_wr_path.sv
module cau_wr_path
  import cau_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_clr,
  input  fmt_e                fmt,
  input  logic                wr_stb,
  input  logic [BYTE_W-1:0]   wr_byte,
  output logic                complete,
  output logic [2*BYTE_W-1:0] init_q,
  output logic                written_q
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              hi_pend_q;
  logic [CNT_W-1:0]  nxt_cnt;

  always_comb begin
    complete = 1'b0;
    nxt_cnt  = {hi_q, lo_q};
    if (wr_stb && !mode_clr) begin
      case (fmt)
        FMT_LO: begin
          complete = 1'b1;
          nxt_cnt  = {hi_q, wr_byte};
        end
        FMT_HI: begin
          complete = 1'b1;
          nxt_cnt  = {wr_byte, lo_q};
        end
        FMT_BOTH: begin
          if (hi_pend_q) begin
            complete = 1'b1;
            nxt_cnt  = {wr_byte, lo_q};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      hi_q      <= '0;
      hi_pend_q <= 1'b0;
      init_q    <= '0;
      written_q <= 1'b0;
    end else begin
      written_q <= complete;
      if (complete) init_q <= nxt_cnt;
      if (mode_clr) begin
        lo_q      <= '0;
        hi_q      <= '0;
        hi_pend_q <= 1'b0;
      end else if (wr_stb) begin
        case (fmt)
          FMT_LO: lo_q <= wr_byte;
          FMT_HI: hi_q <= wr_byte;
          FMT_BOTH: begin
            if (hi_pend_q) hi_q <= wr_byte;
            else           lo_q <= wr_byte;
            hi_pend_q <= !hi_pend_q;
          end
          default: ;
        endcase
      end
    end
  end

  assert_first_byte_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !mode_clr && fmt == FMT_BOTH && !hi_pend_q) |=> !written_q);

  assert_low_only_zero_high_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_clr) ##1 (wr_stb && !mode_clr && fmt == FMT_LO)
      |=> (written_q && init_q == {{BYTE_W{1'b0}}, $past(wr_byte)}));
endmodule

// File: rtl/cau_null_flag.sv
module cau_null_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic null_q
);
  always_ff @(posedge clk) begin
    if (rst)        null_q <= 1'b0;
    else if (set_i) null_q <= 1'b1;
    else if (clr_i) null_q <= 1'b0;
  end

  assert_null_set_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> null_q);

  assert_null_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !null_q);
endmodule

// File: rtl/cau_rd_path.sv
module cau_rd_path
  import cau_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_clr,
  input  fmt_e                fmt,
  input  logic                rd_stb,
  input  logic                frz_cnt,
  input  logic                frz_sts,
  input  logic [2*BYTE_W-1:0] live,
  input  logic [BYTE_W-1:0]   sts_in,
  output logic [BYTE_W-1:0]   rd_q
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  ol_q;
  logic [BYTE_W-1:0] sts_q;
  logic              cnt_lat_q, sts_lat_q, hi_pend_q;
  logic [CNT_W-1:0]  src;
  logic [BYTE_W-1:0] rd_byte;
  logic              rd_done;

  assign src = cnt_lat_q ? ol_q : live;

  always_comb begin
    rd_done = 1'b0;
    rd_byte = src[BYTE_W-1:0];
    if (sts_lat_q) begin
      rd_byte = sts_q;
    end else begin
      case (fmt)
        FMT_HI: begin
          rd_byte = src[CNT_W-1:BYTE_W];
          rd_done = 1'b1;
        end
        FMT_BOTH: begin
          if (hi_pend_q) begin
            rd_byte = src[CNT_W-1:BYTE_W];
            rd_done = 1'b1;
          end
        end
        default: rd_done = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_stb) begin
      rd_q <= rd_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ol_q      <= '0;
      sts_q     <= '0;
      cnt_lat_q <= 1'b0;
      sts_lat_q <= 1'b0;
      hi_pend_q <= 1'b0;
    end else if (mode_clr) begin
      cnt_lat_q <= 1'b0;
      sts_lat_q <= 1'b0;
      hi_pend_q <= 1'b0;
    end else begin
      if (rd_stb) begin
        if (sts_lat_q) begin
          sts_lat_q <= 1'b0;
        end else begin
          if (fmt == FMT_BOTH) hi_pend_q <= !hi_pend_q;
          if (rd_done) cnt_lat_q <= 1'b0;
        end
      end
      if (frz_cnt && !cnt_lat_q) begin
        ol_q      <= live;
        cnt_lat_q <= 1'b1;
      end
      if (frz_sts && !sts_lat_q) begin
        sts_q     <= sts_in;
        sts_lat_q <= 1'b1;
      end
    end
  end

  assert_frozen_count_held_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_lat_q && !rd_stb && !mode_clr) |=> $stable(ol_q));

  assert_status_read_first_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && sts_lat_q && !mode_clr) |=> (rd_q == $past(sts_q)));
endmodule

// File: rtl/cnt_access_unit.sv
module cnt_access_unit
  import cau_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [BYTE_W-3:0]   cfg_data,
  input  logic                cnt_wr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                cnt_rd,
  input  logic                frz_cnt,
  input  logic                frz_sts,
  input  logic [2*BYTE_W-1:0] live_cnt,
  input  logic                out_level,
  input  logic                load_done,
  output logic [2*BYTE_W-1:0] init_cnt,
  output logic                cnt_written,
  output logic [BYTE_W-1:0]   rd_data
);
  localparam int CFG_W = BYTE_W - 2;
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(6'b11_000_0);

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_acc, wr_complete, null_q;
  fmt_e             fmt;

  assign cfg_acc = cfg_wr && (cfg_data[CFG_FMT_MSB:CFG_FMT_LSB] != FMT_NONE);
  assign fmt     = fmt_e'(cfg_q[CFG_FMT_MSB:CFG_FMT_LSB]);

  always_ff @(posedge clk) begin
    if (rst)          cfg_q <= CFG_RST;
    else if (cfg_acc) cfg_q <= cfg_data;
  end

  cau_wr_path #(.BYTE_W(BYTE_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .mode_clr  (cfg_acc),
    .fmt       (fmt),
    .wr_stb    (cnt_wr),
    .wr_byte   (wr_data),
    .complete  (wr_complete),
    .init_q    (init_cnt),
    .written_q (cnt_written)
  );

  cau_null_flag u_null (
    .clk    (clk),
    .rst    (rst),
    .set_i  (cfg_acc || wr_complete),
    .clr_i  (load_done),
    .null_q (null_q)
  );

  cau_rd_path #(.BYTE_W(BYTE_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .mode_clr (cfg_acc),
    .fmt      (fmt),
    .rd_stb   (cnt_rd),
    .frz_cnt  (frz_cnt),
    .frz_sts  (frz_sts),
    .live     (live_cnt),
    .sts_in   ({out_level, null_q, cfg_q}),
    .rd_q     (rd_data)
  );

  assert_ignored_cfg_R12: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_data[CFG_FMT_MSB:CFG_FMT_LSB] == FMT_NONE) |=> $stable(cfg_q));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_written && !cnt_wr) |=> !cnt_written);
endmodule

// File: tb/sim_cnt_access_unit.sv
module sim_cnt_access_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_data = '0;
  logic        cnt_wr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        cnt_rd = 1'b0;
  logic        frz_cnt = 1'b0;
  logic        frz_sts = 1'b0;
  logic [15:0] live_cnt = '0;
  logic        out_level = 1'b0;
  logic        load_done = 1'b0;
  logic [15:0] init_cnt;
  logic        cnt_written;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;

  cnt_access_unit u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .cnt_wr(cnt_wr), .wr_data(wr_data), .cnt_rd(cnt_rd),
    .frz_cnt(frz_cnt), .frz_sts(frz_sts), .live_cnt(live_cnt),
    .out_level(out_level), .load_done(load_done), .init_cnt(init_cnt),
    .cnt_written(cnt_written), .rd_data(rd_data)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_cfg(input logic [5:0] c);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = c;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); cnt_wr = 1'b1; wr_data = d;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
    @(negedge clk); cnt_rd = 1'b1;
    @(negedge clk); cnt_rd = 1'b0;
  endtask

  task automatic freeze(input bit c, input bit s);
    @(negedge clk); frz_cnt = c; frz_sts = s;
    @(negedge clk); frz_cnt = 1'b0; frz_sts = 1'b0;
  endtask

  task automatic loaded();
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops the expected byte for each read the design takes.
  initial begin
    forever begin
      @(posedge clk);
      if (cnt_rd === 1'b1) begin
        #1;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected read: actual %h expected none", rd_data);
        end else begin
          logic [7:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (rd_data !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, rd_data, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd_data, 16'h0000, "R1 rd_data");
    chk(init_cnt, 16'h0000, "R1 init_cnt");
    chk(cnt_written, 16'h0000, "R1 cnt_written");
    freeze(1'b0, 1'b1);
    rd_exp(8'h30, "R1 R8 reset status");

    // R2 low-only, R9 null set by config
    pulse_cfg(6'h14);
    out_level = 1'b1;
    freeze(1'b0, 1'b1);
    rd_exp(8'hD4, "R8 R9 status after config");
    wr_byte(8'h5A);
    chk(cnt_written, 16'h0001, "R2 pulse low-only");
    chk(init_cnt, 16'h005A, "R2 low-only count");
    loaded();
    freeze(1'b0, 1'b1);
    rd_exp(8'h94, "R9 null cleared by load_done");

    // R2 high-only, R4 read high
    pulse_cfg(6'h20);
    wr_byte(8'hA7);
    chk(init_cnt, 16'hA700, "R2 high-only count");
    live_cnt = 16'h1234;
    rd_exp(8'h12, "R4 high-only read");

    // R3 two-byte, R13 decimal pass-through, R9 second byte sets null
    pulse_cfg(6'h37);
    out_level = 1'b0;
    loaded();
    freeze(1'b0, 1'b1);
    rd_exp(8'h37, "R9 null clear before write");
    wr_byte(8'h9F);
    chk(cnt_written, 16'h0000, "R3 first byte silent");
    chk(init_cnt, 16'hA700, "R3 count unchanged after first byte");
    freeze(1'b0, 1'b1);
    rd_exp(8'h37, "R9 first byte leaves null clear");
    wr_byte(8'hCE);
    chk(cnt_written, 16'h0001, "R3 second byte pulse");
    chk(init_cnt, 16'hCE9F, "R3 R13 both bytes unchanged");
    @(negedge clk);
    chk(cnt_written, 16'h0000, "R3 pulse one cycle");
    freeze(1'b0, 1'b1);
    rd_exp(8'h77, "R9 second byte sets null");

    // R5 freeze, R6 repeat freeze ignored
    live_cnt = 16'hBEEF;
    freeze(1'b1, 1'b0);
    live_cnt = 16'h1357;
    freeze(1'b1, 1'b0);
    live_cnt = 16'h2468;
    rd_exp(8'hEF, "R5 R6 frozen low");
    rd_exp(8'hBE, "R5 R6 frozen high");
    rd_exp(8'h68, "R5 follows live low");
    rd_exp(8'h24, "R5 follows live high");

    // R7 status ahead of count
    live_cnt = 16'h4321;
    out_level = 1'b1;
    freeze(1'b1, 1'b0);
    freeze(1'b0, 1'b1);
    out_level = 1'b0;
    freeze(1'b0, 1'b1);
    live_cnt = 16'h9999;
    rd_exp(8'hF7, "R7 R6 status first");
    rd_exp(8'h21, "R7 count low");
    rd_exp(8'h43, "R7 count high");
    rd_exp(8'h99, "R7 unlatched low");
    rd_exp(8'h99, "R7 unlatched high");

    // R10 interleaved reads and writes
    live_cnt = 16'h5678;
    rd_exp(8'h78, "R10 read low");
    wr_byte(8'h11);
    chk(cnt_written, 16'h0000, "R10 write low silent");
    rd_exp(8'h56, "R10 read high");
    wr_byte(8'h22);
    chk(init_cnt, 16'h2211, "R10 write pair");

    // R11 configuration resets pointers and pending freezes
    wr_byte(8'h44);
    live_cnt = 16'hAAAA;
    freeze(1'b1, 1'b0);
    rd_exp(8'hAA, "R11 partial read");
    freeze(1'b0, 1'b1);
    pulse_cfg(6'h37);
    live_cnt = 16'h0F0E;
    wr_byte(8'h01);
    wr_byte(8'h02);
    chk(init_cnt, 16'h0201, "R11 write pointer reset");
    rd_exp(8'h0E, "R11 read pointer and freezes reset");
    rd_exp(8'h0F, "R11 high after reset");

    // R12 format 00 configuration ignored
    loaded();
    pulse_cfg(6'h04);
    freeze(1'b0, 1'b1);
    rd_exp(8'h37, "R12 config and null unchanged");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule